// File: doc/BRIEF.md
# Level-0 Discriminator Trigger Unit

This block sits behind a bank of seven analogue discriminators in a multi-channel detector front end and decides, clock by clock, whether a particle hit deserves a level-0 trigger. Every discriminator line is synchronised and edge-detected. A rising edge on any enabled line produces a short fixed-width hit pulse. The synchronised discriminator pattern is also looked up in a writable 128-entry truth table. If the table entry is set and the unit is not already busy, a longer fixed-width event pulse starts and the pattern is latched for the later readout.

After an event, the unit waits for an accept strobe from the acquisition system. If the accept comes within a programmable window, the unit enters a readout phase, which ends on a readout-done strobe. If the accept does not come in time, the unit issues a one-cycle shaper-reset request, clears the latched pattern and returns to idle. A sticky pile-up flag records any enabled hit that arrives while an event pulse is running or a readout is outstanding.

Top module: `trig_unit`

## Requirements
- R1: Each discriminator input passes through two synchronising flops, and only a 0-to-1 transition counts as a hit. Outputs react at the third rising clock edge after the first edge that samples the new level. A level held high produces no further hits.
- R2: An enabled hit starts `hit_pulse`, which stays high for exactly HIT_LEN cycles (default 5). Hits that arrive while it is high neither restart nor lengthen it.
- R3: In the same cycle as the hit pulse, `event_pulse` starts and stays high for EVENT_LEN cycles (default 20). This happens only if the table entry for the synchronised discriminator vector is 1 and no event is running and no readout is outstanding.
- R4: When `cfg_we` is high, `cfg_bit` is written to the truth-table entry at `cfg_addr`. The address is the discriminator vector, with bit i being discriminator i.
- R5: While `trig_en` is low, rising edges produce no hit pulse, no event pulse and no pile-up.
- R6: After an event starts, the unit waits up to TIMEOUT cycles (default 100) for `accept`. The last edge that still counts is the TIMEOUT-th edge after the event starts. If no accept is sampled by then, `shaper_rst` is high for exactly one cycle, `pattern` becomes 0 and the unit returns to idle.
- R7: `pileup` is set by an enabled hit that arrives while `event_pulse` is high or an accept or readout is outstanding. It stays set until `readout_done` is sampled during the readout phase. If a new setting hit arrives in that same cycle, the flag stays set.
- R8: `pattern` captures the synchronised discriminator vector when an event starts. It holds that value through the readout.
- R9: Synchronous reset drives all outputs to 0.
- R10: `accept` has no effect unless the unit is waiting for it. `readout_done` has no effect outside the readout phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst | input | 1 | synchronous active-high reset |
| disc_in | input | 7 | asynchronous discriminator outputs |
| trig_en | input | 1 | trigger enable configuration bit |
| cfg_we | input | 1 | truth-table write strobe |
| cfg_addr | input | 7 | truth-table entry to write |
| cfg_bit | input | 1 | value written to the entry |
| accept | input | 1 | accept strobe from acquisition |
| readout_done | input | 1 | readout completion strobe |
| hit_pulse | output | 1 | short level-0 hit pulse |
| event_pulse | output | 1 | long qualified event pulse |
| shaper_rst | output | 1 | one-cycle shaper reset request |
| pileup | output | 1 | sticky pile-up flag |
| pattern | output | 7 | latched discriminator vector |

## Verification
The bench sweeps the accept strobe across the end of the timeout window. A design with an off-by-one window would either reset the shapers on an accept that arrived in time, or let a late accept start a readout. A second edge is placed inside a running hit pulse, and a level is held high for many cycles. Either would expose a pulse that restarts, or an edge detector that fires on level. Overlapping hits during an event and during readout check that the pile-up flag is sticky and is cleared only by readout completion. A flag cleared by a timeout or by a stray strobe would diverge from the model. The truth table is reprogrammed mid-run, disabled triggering is exercised, and stray accept and done strobes are issued while the unit is idle or waiting.

// File: rtl/trig_pkg.sv
package trig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_READ = 2'd2
  } rd_state_t;
endpackage

// File: rtl/disc_sync.sv
module disc_sync #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  logic [N-1:0] meta, stab, prev;

  for (genvar i = 0; i < N; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[i] <= 1'b0;
        stab[i] <= 1'b0;
        prev[i] <= 1'b0;
      end else begin
        meta[i] <= din[i];
        stab[i] <= meta[i];
        prev[i] <= stab[i];
      end
    end
  end

  assign level = stab;
  assign rise  = stab & ~prev;

  // R1: an edge is reported for one cycle only
  a_r1_rise_single: assert property (@(posedge clk) disable iff (rst)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/cond_lut.sv
module cond_lut #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wbit,
  input  logic [AW-1:0] raddr,
  output logic          rdata
);
  localparam int DEPTH = 2 ** AW;
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen #(
  parameter int LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic active
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(LEN);
  localparam logic [CW-1:0] ONE  = CW'(1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= '0;
    else if (fire && cnt == '0)    cnt <= LOAD;
    else if (cnt != '0)            cnt <= cnt - ONE;
  end

  assign active = (cnt != '0);

  // R2: a running pulse is never restarted or stretched
  a_r2_no_extend: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/trig_unit.sv
module trig_unit
  import trig_pkg::*;
#(
  parameter int N_DISC    = 7,
  parameter int HIT_LEN   = 5,
  parameter int EVENT_LEN = 20,
  parameter int TIMEOUT   = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_DISC-1:0] disc_in,
  input  logic              trig_en,
  input  logic              cfg_we,
  input  logic [N_DISC-1:0] cfg_addr,
  input  logic              cfg_bit,
  input  logic              accept,
  input  logic              readout_done,
  output logic              hit_pulse,
  output logic              event_pulse,
  output logic              shaper_rst,
  output logic              pileup,
  output logic [N_DISC-1:0] pattern
);
  localparam int TW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [TW-1:0] TMO_LOAD = TW'(TIMEOUT - 1);
  localparam logic [TW-1:0] TONE     = TW'(1);

  logic [N_DISC-1:0] lvl, rise, pat_v;
  logic              hit_v, qual, fire, busy, start_ev;
  rd_state_t         state;
  logic [TW-1:0]     tmo;

  disc_sync #(.N(N_DISC)) u_sync (
    .clk(clk), .rst(rst), .din(disc_in), .level(lvl), .rise(rise)
  );

  cond_lut #(.AW(N_DISC)) u_lut (
    .clk(clk), .we(cfg_we), .waddr(cfg_addr), .wbit(cfg_bit),
    .raddr(lvl), .rdata(qual)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_v <= 1'b0;
      pat_v <= '0;
    end else begin
      hit_v <= (rise != '0);
      pat_v <= lvl;
    end
  end

  assign fire     = hit_v & trig_en;
  assign busy     = event_pulse | (state != ST_IDLE);
  assign start_ev = fire & qual & ~busy;

  pulse_gen #(.LEN(HIT_LEN)) u_hit (
    .clk(clk), .rst(rst), .fire(fire), .active(hit_pulse)
  );

  pulse_gen #(.LEN(EVENT_LEN)) u_evt (
    .clk(clk), .rst(rst), .fire(start_ev), .active(event_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      tmo        <= '0;
      shaper_rst <= 1'b0;
      pattern    <= '0;
    end else begin
      shaper_rst <= 1'b0;
      case (state)
        ST_WAIT: begin
          if (accept) begin
            state <= ST_READ;
          end else if (tmo == '0) begin
            state      <= ST_IDLE;
            shaper_rst <= 1'b1;
            pattern    <= '0;
          end else begin
            tmo <= tmo - TONE;
          end
        end
        ST_READ: if (readout_done) state <= ST_IDLE;
        default: ;
      endcase
      if (start_ev) begin
        state   <= ST_WAIT;
        tmo     <= TMO_LOAD;
        pattern <= pat_v;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                   pileup <= 1'b0;
    else if (fire && busy)                     pileup <= 1'b1;
    else if (state == ST_READ && readout_done) pileup <= 1'b0;
  end

  // R6: the reset request lasts one cycle
  a_r6_srst_single: assert property (@(posedge clk) disable iff (rst)
    shaper_rst |=> !shaper_rst);
  // R6: pattern is empty when the reset request is raised
  a_r6_srst_clears: assert property (@(posedge clk) disable iff (rst)
    shaper_rst |-> (pattern == '0));
  // R5: a hit pulse only starts when triggering was enabled
  a_r5_enabled_only: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_pulse) |-> $past(trig_en));
  // R3: an event only starts from idle
  a_r3_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(event_pulse) |-> ($past(state) == ST_IDLE && state == ST_WAIT));
  // R7: pile-up stays set unless readout completes
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (pileup && !(state == ST_READ && readout_done)) |=> pileup);
  // R8: latched pattern is held through readout
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (state == ST_READ && $past(state) == ST_READ) |-> $stable(pattern));
endmodule

// File: tb/test_trig_unit.sv
module test_trig_unit;
  localparam int HIT_LEN = 5, EVENT_LEN = 20, TIMEOUT = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] disc_in = '0;
  logic trig_en = 1'b1, cfg_we = 1'b0, cfg_bit = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic accept = 1'b0, readout_done = 1'b0;
  logic hit_pulse, event_pulse, shaper_rst, pileup;
  logic [6:0] pattern;

  int vectors = 0, errors = 0;
  bit started = 0;

  always #5 clk = ~clk;

  trig_unit i_trig_unit (
    .clk(clk), .rst(rst), .disc_in(disc_in), .trig_en(trig_en),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_bit(cfg_bit),
    .accept(accept), .readout_done(readout_done),
    .hit_pulse(hit_pulse), .event_pulse(event_pulse),
    .shaper_rst(shaper_rst), .pileup(pileup), .pattern(pattern)
  );

  // reference model
  logic [6:0] hist[$];
  bit mlut [128];
  int m_hit, m_ev, m_st, waited;
  bit m_pile, m_srst;
  logic [6:0] m_pat;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      hist = '{7'h0, 7'h0, 7'h0, 7'h0, 7'h0};
      m_hit = 0; m_ev = 0; m_st = 0; waited = 0;
      m_pile = 0; m_srst = 0; m_pat = '0;
    end else begin
      logic [6:0] edges;
      bit fire, busy, qual;
      hist.push_front(disc_in);
      void'(hist.pop_back());
      edges = hist[3] & ~hist[4];
      fire  = (edges != 0) && trig_en;
      busy  = (m_ev != 0) || (m_st != 0);
      qual  = mlut[hist[3]];
      m_srst = 0;
      if (m_hit != 0) m_hit--; else if (fire) m_hit = HIT_LEN;
      if (m_ev != 0) m_ev--;
      if (m_st == 1) begin
        if (accept) m_st = 2;
        else if (waited == TIMEOUT - 1) begin m_srst = 1; m_st = 0; m_pat = '0; end
        else waited++;
      end else if (m_st == 2 && readout_done) begin
        m_st = 0; m_pile = 0;
      end
      if (fire && busy) m_pile = 1;
      if (fire && !busy && qual) begin
        m_ev = EVENT_LEN; m_st = 1; waited = 0; m_pat = hist[3];
      end
    end
    if (cfg_we) mlut[cfg_addr] = cfg_bit;
  end

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      vectors++;
      if (rst) chk("R9 reset outputs", {2'b0, hit_pulse, event_pulse, shaper_rst, pileup}, 7'h0);
      chk("R1,R2,R5 hit_pulse", {6'b0, hit_pulse}, {6'b0, m_hit != 0});
      chk("R3,R4 event_pulse", {6'b0, event_pulse}, {6'b0, m_ev != 0});
      chk("R6,R10 shaper_rst", {6'b0, shaper_rst}, {6'b0, m_srst});
      chk("R5,R7 pileup", {6'b0, pileup}, {6'b0, m_pile});
      chk("R8 pattern", pattern, m_pat);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(logic [6:0] mask, int len);
    disc_in = mask; idle(len); disc_in = '0;
  endtask

  task automatic strobe_acc();
    accept = 1'b1; idle(1); accept = 1'b0;
  endtask

  task automatic strobe_done();
    readout_done = 1'b1; idle(1); readout_done = 1'b0;
  endtask

  task automatic load_lut(int sel);
    for (int a = 0; a < 128; a++) begin
      logic [6:0] v = 7'(a);
      cfg_we = 1'b1; cfg_addr = v;
      cfg_bit = (sel == 0) ? (v[6] | (v[0] & v[1])) : v[2];
      idle(1);
    end
    cfg_we = 1'b0;
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    load_lut(0);                              // R4
    idle(5);
    pulse(7'h04, 3); idle(20);                // hit without event
    strobe_acc(); strobe_done(); idle(5);     // R10 stray strobes while idle
    pulse(7'h40, 2); idle(10);                // qualified event
    strobe_done(); idle(3);                   // R10 done while waiting
    strobe_acc(); idle(5); strobe_done(); idle(30);
    pulse(7'h03, 4); idle(120);               // R6 timeout
    pulse(7'h40, 2); idle(6);                 // R7 pile-up during event
    pulse(7'h08, 2); idle(10);
    strobe_acc(); idle(5);
    pulse(7'h10, 2); idle(8);                 // R7 pile-up during readout
    strobe_done(); idle(10);
    trig_en = 1'b0; pulse(7'h7f, 3); idle(20); trig_en = 1'b1;   // R5
    pulse(7'h01, 1); idle(1); pulse(7'h02, 1); idle(20);       // R2 no extend
    pulse(7'h40, 50); idle(150);              // R1 held level
    for (int d = 95; d <= 103; d++) begin     // R6 window boundary
      pulse(7'h40, 1); idle(d - 1);
      strobe_acc(); idle(4); strobe_done(); idle(25);
    end
    load_lut(1); idle(5);                     // R4 reprogram
    pulse(7'h04, 2); idle(10); strobe_acc(); idle(3); strobe_done(); idle(25);
    pulse(7'h40, 2); idle(30);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule